// File: doc/BRIEF.md
# Divide-by-sixty BCD counter

This block counts enabled clock cycles modulo sixty and shows the count as two decimal digits: a four-bit BCD units digit and a three-bit tens digit. It is meant to turn a fast periodic tick into a slow one. One example is turning a 60 Hz strobe into a 1 Hz strobe. To do this, drive the count enable with the fast strobe and use the terminal pulse as the slow one.

The units stage is a decade counter. It finds its last state by looking at only its most and least significant bits. The tens stage advances only when the units stage is at its last state. It returns to zero in place of reaching six, so the pair runs from 00 to 59. Every flip-flop shares one clock and one synchronous reset, and the digits never show a transient illegal value.

Top module: `mod60_counter`

## Requirements
- R1: With the enable high, the units digit advances by one on each clock edge, through the binary codes 0 to 9.
- R2: An enabled edge that finds the units digit at 9 (binary 1001) returns it to 0. The last state is recognised from units bits 3 and 0 alone.
- R3: The tens digit advances by one only on an enabled edge where the units digit is 9. At all other times it holds.
- R4: An enabled edge at count 59 returns both digits to 00 on that same edge. The tens output never shows 6 or 7.
- R5: The terminal pulse is high exactly while the enable is high and the count is 59. Two successive pulses are 60 enabled cycles apart.
- R6: While the enable is low, both digits hold their values and the terminal pulse stays low.
- R7: A high synchronous reset clears both digits to 0 on the next edge, whatever the enable is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable; one count per edge while high |
| units_o | output | 4 | Units digit, BCD |
| tens_o | output | 3 | Tens digit, binary 0 to 5 |
| tick_o | output | 1 | Terminal pulse, high during the enabled cycle at count 59 |

## Verification
A wrong units value shows on units_o at the very next edge. Because the tens enable depends on the units state, the same error moves the tens step and the terminal pulse by up to ten enabled cycles. A wrong tens value shows on tens_o at once, and it also shifts tick_o, which then breaks the 60-cycle spacing between pulses. The bench compares both digits and the pulse against a behavioural count on every clock. It also measures the spacing between pulses, so an error in either digit is seen within one period.

// File: rtl/mod60_pkg.sv
package mod60_pkg;
    parameter int UNITS_W = 4;
    parameter int TENS_W  = 3;

    typedef logic [UNITS_W-1:0] units_t;
    typedef logic [TENS_W-1:0]  tens_t;

    typedef struct packed {
        units_t digit;
    } units_state_t;

    typedef struct packed {
        tens_t digit;
    } tens_state_t;
endpackage

// File: rtl/mod60_units.sv
module mod60_units
    import mod60_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   step,
    output units_t digit,
    output logic   at_last
);
    localparam int HI_BIT = UNITS_W - 1;

    units_state_t st_d, st_q;
    logic         last_hit;

    always_comb begin
        // Nine is the first code in the decade with both end bits set
        last_hit = st_q.digit[HI_BIT] & st_q.digit[0];
        st_d     = st_q;
        if (rst) begin
            st_d.digit = '0;
        end else if (step) begin
            if (last_hit) st_d.digit = '0;
            else          st_d.digit = st_q.digit + units_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign digit   = st_q.digit;
    assign at_last = last_hit;

    AST_UNITS_BCD: assert property (@(posedge clk) disable iff (rst)
        st_q.digit <= units_t'(9)); // R1
    AST_UNITS_WRAP: assert property (@(posedge clk) disable iff (rst)
        (step && st_q.digit == units_t'(9)) |=> st_q.digit == '0); // R2
    AST_UNITS_STEP: assert property (@(posedge clk) disable iff (rst)
        (step && st_q.digit != units_t'(9)) |=> st_q.digit == $past(st_q.digit) + units_t'(1)); // R1
endmodule

// File: rtl/mod60_tens.sv
module mod60_tens
    import mod60_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  step,
    output tens_t digit,
    output logic  at_last
);
    localparam int HI_BIT = TENS_W - 1;

    tens_state_t st_d, st_q;
    logic        five_hit;

    always_comb begin
        // Five is the first code in 0..5 with both end bits set
        five_hit = st_q.digit[HI_BIT] & st_q.digit[0];
        st_d     = st_q;
        if (rst) begin
            st_d.digit = '0;
        end else if (step) begin
            if (five_hit) st_d.digit = '0;
            else          st_d.digit = st_q.digit + tens_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign digit   = st_q.digit;
    assign at_last = five_hit;

    AST_TENS_RANGE: assert property (@(posedge clk) disable iff (rst)
        st_q.digit <= tens_t'(5)); // R4
    AST_TENS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(st_q.digit)); // R3
endmodule

// File: rtl/mod60_counter.sv
module mod60_counter
    import mod60_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cnt_en,
    output logic [UNITS_W-1:0] units_o,
    output logic [TENS_W-1:0]  tens_o,
    output logic               tick_o
);
    units_t units_w;
    tens_t  tens_w;
    logic   units_last;
    logic   tens_last;
    logic   tens_step;

    assign tens_step = cnt_en & units_last;

    mod60_units u_units (
        .clk     (clk),
        .rst     (rst),
        .step    (cnt_en),
        .digit   (units_w),
        .at_last (units_last)
    );

    mod60_tens u_tens (
        .clk     (clk),
        .rst     (rst),
        .step    (tens_step),
        .digit   (tens_w),
        .at_last (tens_last)
    );

    assign units_o = units_w;
    assign tens_o  = tens_w;
    assign tick_o  = tens_step & tens_last;

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o); // R5
    AST_TICK_WRAP: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> (units_o == '0 && tens_o == '0)); // R4
    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> ($stable(units_o) && $stable(tens_o))); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |-> !tick_o); // R6
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (units_o == '0 && tens_o == '0)); // R7
endmodule

// File: tb/mod60_counter_bench.sv
module mod60_counter_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic [3:0] units_o;
    logic [2:0] tens_o;
    logic       tick_o;

    int checks = 0;
    int errors = 0;
    int model  = 0;
    int since_tick = 0;
    bit seen_tick = 1'b0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    mod60_counter u_mod60_counter (
        .clk     (clk),
        .rst     (rst),
        .cnt_en  (cnt_en),
        .units_o (units_o),
        .tens_o  (tens_o),
        .tick_o  (tick_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive at falling edge, check the pulse there, advance model and compare digits after rising edge
    task automatic cycle(input bit r, input bit e);
        string ut;
        string tt;
        int prev;
        @(negedge clk);
        rst    = r;
        cnt_en = e;
        #1;
        check(tick_o == (e && model == 59), e ? "R5" : "R6", int'(tick_o), int'(e && model == 59));
        if (!r && e && tick_o) begin
            if (seen_tick) check(since_tick == 59, "R5 period", since_tick + 1, 60);
            seen_tick  = 1'b1;
            since_tick = 0;
        end else if (!r && e) begin
            since_tick++;
        end
        prev = model;
        if (r)      model = 0;
        else if (e) model = (model + 1) % 60;
        if (r)                       begin ut = "R7"; tt = "R7"; end
        else if (!e)                 begin ut = "R6"; tt = "R6"; end
        else if (prev == 59)         begin ut = "R4"; tt = "R4"; end
        else if (prev % 10 == 9)     begin ut = "R2"; tt = "R3"; end
        else                         begin ut = "R1"; tt = "R3"; end
        @(posedge clk);
        #1;
        check(int'(units_o) == model % 10, ut, int'(units_o), model % 10);
        check(int'(tens_o) == model / 10, tt, int'(tens_o), model / 10);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) cycle(1'b1, 1'b0);       // R7 reset state
        for (int i = 0; i < 130; i++) cycle(1'b0, 1'b1);     // R1..R5 full sequence twice
        for (int i = 0; i < 200; i++) cycle(1'b0, (i % 3) != 0); // R6 gated counting
        for (int i = 0; i < 15; i++) cycle(1'b0, 1'b0);      // R6 long hold
        cycle(1'b1, 1'b1);                                   // R7 reset over enable
        since_tick = 0;
        seen_tick  = 1'b0;
        for (int i = 0; i < 70; i++) cycle(1'b0, 1'b1);
        for (int i = 0; i < 7; i++) cycle(1'b0, 1'b1);       // reach 59 then hold it
        while (model != 59) cycle(1'b0, 1'b1);
        for (int i = 0; i < 4; i++) cycle(1'b0, 1'b0);       // R6 pulse suppressed at 59
        for (int i = 0; i < 125; i++) cycle(1'b0, 1'b1);     // R5 period after idle
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule